// File: doc/BRIEF.md
# Parallel Flash Read-Path Mode Controller

This block is the device side of an asynchronous parallel NOR-style flash read port, modelled as a synchronous circuit. Each clock it samples chip enable, output enable, a byte/word select, the word address and the input side of the top data pin. From these it registers the value for the sixteen data pins, along with separate drive enables for three pin groups: the low byte, pins 8 to 14, and pin 15. A testbench can therefore observe high impedance without resolving an inout.

The block tracks which kind of data a read returns. There are four read modes: array read, identifier (autoselect) read, erase-suspended read and error-latched read. Mode changes arrive as single-cycle strobes from an external command decoder. The array itself is a small word memory kept inside the block. It is written through a program port that stands in for the embedded program algorithm.

In byte mode the top data pin becomes the least-significant address input and picks one byte of the addressed word. While an erase is suspended, reads that fall in a suspended sector return a status pattern instead of array data.

Top module: `flash_rd_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first output after it rises, all three drive enables are 0 and `dq_out` is 0. The block then starts in array-read mode with no command.
- R2: With `ce_n`=0, `oe_n`=0 and `word_mode`=1 sampled at an edge, the next `dq_out` is the full selected word and all three drive enables are 1.
- R3: With `ce_n`=0, `oe_n`=0 and `word_mode`=0, only `dq_oe_lo` is 1 and `dq_out[15:8]` is 0. `dq_out[7:0]` is bits 7:0 of the selected word when `dq_top_in`=0, and bits 15:8 when `dq_top_in`=1.
- R4: With `ce_n`=1, all drive enables are 0 and `dq_out` is 0 on the next cycle, for either level of `oe_n`.
- R5: With `ce_n`=0 and `oe_n`=1, all drive enables are 0 and `dq_out` is 0 on the next cycle.
- R6: In array-read mode, `cmd_suspend` enters erase-suspend mode and loads `susp_sectors` into the suspended-sector map. The sector index is `addr[AW-1:AW-SECW]`. Reads in a marked sector return `SUSP_STATUS`; reads in other sectors return array data.
- R7: `cmd_prog_done` in erase-suspend mode leaves the mode and the map unchanged. Words written through the program port are read back in unsuspended sectors.
- R8: `cmd_resume` in erase-suspend mode returns to array read and clears the map.
- R9: `err_flag` enters the error-latched mode from any mode. There, every read returns `ERR_STATUS` (bit 5 set), and `cmd_autosel`, `cmd_suspend` and `cmd_resume` are ignored until `cmd_reset`.
- R10: `cmd_autosel` from array read or erase suspend enters identifier mode. There, `addr[1:0]`=0 reads `MFR_ID`, 1 reads `DEV_ID`, 2 reads the protection flag `prot_sectors[sector]` in bit 0 with the other bits 0, and 3 reads 0. `cmd_suspend` and `cmd_resume` are ignored until `cmd_reset`.
- R11: `cmd_reset` returns to array read and clears the map from any mode. It wins over every other strobe in the same cycle. Otherwise the order of precedence is `err_flag`, `cmd_autosel`, `cmd_suspend`, `cmd_resume`.
- R12: Strobes and program writes take effect for reads sampled at the following edge. A read in the same cycle sees the old mode and the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = 16-bit reads, 0 = byte reads |
| addr | input | AW | Word address |
| dq_top_in | input | 1 | Input side of data pin 15, byte select in byte mode |
| dq_out | output | 16 | Registered data pin values |
| dq_oe_lo | output | 1 | Drive enable for pins 7:0 |
| dq_oe_mid | output | 1 | Drive enable for pins 14:8 |
| dq_oe_top | output | 1 | Drive enable for pin 15 |
| prog_we | input | 1 | Array program write strobe |
| prog_addr | input | AW | Program write address |
| prog_data | input | 16 | Program write word |
| cmd_reset | input | 1 | Reset command strobe |
| cmd_autosel | input | 1 | Identifier mode entry strobe |
| cmd_suspend | input | 1 | Erase suspend strobe |
| cmd_resume | input | 1 | Erase resume strobe |
| cmd_prog_done | input | 1 | Program completion strobe |
| err_flag | input | 1 | Status error bit set strobe |
| susp_sectors | input | NSEC | Sectors under the suspended erase |
| prot_sectors | input | NSEC | Per-sector protection flags |

## Verification
The directed part walks each mode in turn. It reads the same addresses in word mode and in both byte halves, so a wrong byte pick or a leaked upper group shows up. Suspended and unsuspended sectors are read side by side, which separates the sector decode from the mode decode. Identifier reads sweep all four low address codes and both protection values. The random part mixes reads, program writes and overlapping strobes with enables toggling on every cycle, which exposes errors in strobe precedence, same-cycle ordering and tri-state gating.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [1:0] {
        MD_ARRAY   = 2'd0,
        MD_AUTOSEL = 2'd1,
        MD_SUSP    = 2'd2,
        MD_ERR     = 2'd3
    } rd_mode_e;

    typedef struct packed {
        logic [15:0] dout;
        logic        oe_lo;
        logic        oe_mid;
        logic        oe_top;
    } pin_drive_t;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
    import flash_rd_pkg::*;
#(
    parameter int NSEC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_reset,
    input  logic            cmd_autosel,
    input  logic            cmd_suspend,
    input  logic            cmd_resume,
    input  logic            cmd_prog_done,
    input  logic            err_flag,
    input  logic [NSEC-1:0] susp_sectors,
    output rd_mode_e        mode_o,
    output logic [NSEC-1:0] map_o
);
    typedef struct packed {
        rd_mode_e        mode;
        logic [NSEC-1:0] map;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_reset) begin
            st_d.mode = MD_ARRAY;
            st_d.map  = '0;
        end else if (err_flag) begin
            st_d.mode = MD_ERR;
        end else begin
            unique case (st_q.mode)
                MD_ARRAY: begin
                    if (cmd_autosel) begin
                        st_d.mode = MD_AUTOSEL;
                    end else if (cmd_suspend) begin
                        st_d.mode = MD_SUSP;
                        st_d.map  = susp_sectors;
                    end
                end
                MD_SUSP: begin
                    if (cmd_autosel) begin
                        st_d.mode = MD_AUTOSEL;
                    end else if (cmd_resume) begin
                        st_d.mode = MD_ARRAY;
                        st_d.map  = '0;
                    end else if (cmd_prog_done) begin
                        st_d.mode = MD_SUSP;
                    end
                end
                MD_AUTOSEL: st_d.mode = MD_AUTOSEL;
                MD_ERR:     st_d.mode = MD_ERR;
                default:    st_d.mode = MD_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MD_ARRAY;
            st_q.map  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign map_o  = st_q.map;
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_rd_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int          SECW        = 2,
    parameter logic [15:0] MFR_ID      = 16'h00A5,
    parameter logic [15:0] DEV_ID      = 16'h22C3,
    parameter logic [15:0] SUSP_STATUS = 16'h0044,
    parameter logic [15:0] ERR_STATUS  = 16'h0060
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic                word_mode,
    input  logic [AW-1:0]       addr,
    input  logic                byte_hi,
    input  rd_mode_e            mode,
    input  logic [(1<<SECW)-1:0] susp_map,
    input  logic [(1<<SECW)-1:0] prot_map,
    input  logic [15:0]         arr_word,
    output logic [15:0]         dq_out,
    output logic                oe_lo,
    output logic                oe_mid,
    output logic                oe_top
);
    localparam int NSEC = 1 << SECW;

    pin_drive_t drv_d, drv_q;
    logic [SECW-1:0] sec_idx;
    logic [15:0]     word_sel;
    logic [15:0]     id_word;
    logic            read_en;

    assign sec_idx = addr[AW-1 -: SECW];
    assign read_en = !ce_n && !oe_n;

    always_comb begin
        unique case (addr[1:0])
            2'd0:    id_word = MFR_ID;
            2'd1:    id_word = DEV_ID;
            2'd2:    id_word = {15'd0, prot_map[sec_idx]};
            default: id_word = 16'h0000;
        endcase
    end

    always_comb begin
        unique case (mode)
            MD_ARRAY:   word_sel = arr_word;
            MD_SUSP:    word_sel = susp_map[sec_idx] ? SUSP_STATUS : arr_word;
            MD_AUTOSEL: word_sel = id_word;
            MD_ERR:     word_sel = ERR_STATUS;
            default:    word_sel = arr_word;
        endcase
    end

    always_comb begin
        drv_d = '0;
        if (read_en) begin
            drv_d.oe_lo = 1'b1;
            if (word_mode) begin
                drv_d.dout   = word_sel;
                drv_d.oe_mid = 1'b1;
                drv_d.oe_top = 1'b1;
            end else begin
                drv_d.dout = {8'h00, (byte_hi ? word_sel[15:8] : word_sel[7:0])};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign dq_out = drv_q.dout;
    assign oe_lo  = drv_q.oe_lo;
    assign oe_mid = drv_q.oe_mid;
    assign oe_top = drv_q.oe_top;

    if (NSEC < 2) begin : g_sec_guard
        initial $error("flash_read_mux needs at least two sectors");
    end
endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
    import flash_rd_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int          SECW        = 2,
    parameter logic [15:0] MFR_ID      = 16'h00A5,
    parameter logic [15:0] DEV_ID      = 16'h22C3,
    parameter logic [15:0] SUSP_STATUS = 16'h0044,
    parameter logic [15:0] ERR_STATUS  = 16'h0060,
    localparam int         NSEC        = 1 << SECW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            word_mode,
    input  logic [AW-1:0]   addr,
    input  logic            dq_top_in,
    output logic [15:0]     dq_out,
    output logic            dq_oe_lo,
    output logic            dq_oe_mid,
    output logic            dq_oe_top,
    input  logic            prog_we,
    input  logic [AW-1:0]   prog_addr,
    input  logic [15:0]     prog_data,
    input  logic            cmd_reset,
    input  logic            cmd_autosel,
    input  logic            cmd_suspend,
    input  logic            cmd_resume,
    input  logic            cmd_prog_done,
    input  logic            err_flag,
    input  logic [NSEC-1:0] susp_sectors,
    input  logic [NSEC-1:0] prot_sectors
);
    rd_mode_e        mode_q;
    logic [NSEC-1:0] susp_map_q;
    logic [15:0]     arr_word;

    flash_array #(.AW(AW), .DW(16)) u_array (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (addr),
        .rdata (arr_word)
    );

    flash_mode_fsm #(.NSEC(NSEC)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_reset     (cmd_reset),
        .cmd_autosel   (cmd_autosel),
        .cmd_suspend   (cmd_suspend),
        .cmd_resume    (cmd_resume),
        .cmd_prog_done (cmd_prog_done),
        .err_flag      (err_flag),
        .susp_sectors  (susp_sectors),
        .mode_o        (mode_q),
        .map_o         (susp_map_q)
    );

    flash_read_mux #(
        .AW(AW), .SECW(SECW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
        .SUSP_STATUS(SUSP_STATUS), .ERR_STATUS(ERR_STATUS)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .word_mode (word_mode),
        .addr      (addr),
        .byte_hi   (dq_top_in),
        .mode      (mode_q),
        .susp_map  (susp_map_q),
        .prot_map  (prot_sectors),
        .arr_word  (arr_word),
        .dq_out    (dq_out),
        .oe_lo     (dq_oe_lo),
        .oe_mid    (dq_oe_mid),
        .oe_top    (dq_oe_top)
    );
endmodule

// File: rtl/flash_rd_chk.sv
module flash_rd_chk
    import flash_rd_pkg::*;
#(
    parameter int NSEC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ce_n,
    input logic            oe_n,
    input logic            word_mode,
    input logic [15:0]     dq_out,
    input logic            dq_oe_lo,
    input logic            dq_oe_mid,
    input logic            dq_oe_top,
    input logic            cmd_reset,
    input logic            cmd_autosel,
    input logic            cmd_resume,
    input logic            err_flag,
    input rd_mode_e        mode_q,
    input logic [NSEC-1:0] susp_map_q
);
    // R4
    standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dq_oe_lo && !dq_oe_mid && !dq_oe_top && dq_out == 16'h0000));

    // R5
    outdis_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> (!dq_oe_lo && !dq_oe_mid && !dq_oe_top && dq_out == 16'h0000));

    // R2
    word_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && word_mode) |=> (dq_oe_lo && dq_oe_mid && dq_oe_top));

    // R3
    byte_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !word_mode) |=>
            (dq_oe_lo && !dq_oe_mid && !dq_oe_top && dq_out[15:8] == 8'h00));

    // R9
    err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !cmd_reset) |=> (mode_q == MD_ERR));

    // R8
    resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_SUSP && cmd_resume && !cmd_reset && !err_flag && !cmd_autosel)
            |=> (mode_q == MD_ARRAY && susp_map_q == '0));

    // R11
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (mode_q == MD_ARRAY && susp_map_q == '0));
endmodule

bind flash_rd_ctrl flash_rd_chk #(.NSEC(NSEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .word_mode  (word_mode),
    .dq_out     (dq_out),
    .dq_oe_lo   (dq_oe_lo),
    .dq_oe_mid  (dq_oe_mid),
    .dq_oe_top  (dq_oe_top),
    .cmd_reset  (cmd_reset),
    .cmd_autosel(cmd_autosel),
    .cmd_resume (cmd_resume),
    .err_flag   (err_flag),
    .mode_q     (mode_q),
    .susp_map_q (susp_map_q)
);

// File: tb/tb_flash_rd_ctrl.sv
module tb_flash_rd_ctrl;
    localparam int          AW   = 8;
    localparam int          SECW = 2;
    localparam int          NSEC = 4;
    localparam logic [15:0] P_MFR  = 16'h00A5;
    localparam logic [15:0] P_DEV  = 16'h22C3;
    localparam logic [15:0] P_SUSP = 16'h0044;
    localparam logic [15:0] P_ERR  = 16'h0060;
    localparam int M_ARR = 0, M_AS = 1, M_SUS = 2, M_ERR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, word_mode = 1'b1, dq_top_in = 1'b0;
    logic [AW-1:0] addr = '0, prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic prog_we = 1'b0;
    logic cmd_reset = 1'b0, cmd_autosel = 1'b0, cmd_suspend = 1'b0;
    logic cmd_resume = 1'b0, cmd_prog_done = 1'b0, err_flag = 1'b0;
    logic [NSEC-1:0] susp_sectors = '0, prot_sectors = '0;
    logic [15:0] dq_out;
    logic dq_oe_lo, dq_oe_mid, dq_oe_top;

    int tests = 0;
    int fails = 0;

    logic [15:0] mem_m [1<<AW];
    int mode_m = M_ARR;
    logic [NSEC-1:0] map_m = '0;

    always #10 clk = ~clk;

    flash_rd_ctrl #(
        .AW(AW), .SECW(SECW), .MFR_ID(P_MFR), .DEV_ID(P_DEV),
        .SUSP_STATUS(P_SUSP), .ERR_STATUS(P_ERR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .word_mode(word_mode),
        .addr(addr), .dq_top_in(dq_top_in), .dq_out(dq_out),
        .dq_oe_lo(dq_oe_lo), .dq_oe_mid(dq_oe_mid), .dq_oe_top(dq_oe_top),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .cmd_reset(cmd_reset), .cmd_autosel(cmd_autosel), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_prog_done(cmd_prog_done), .err_flag(err_flag),
        .susp_sectors(susp_sectors), .prot_sectors(prot_sectors)
    );

    function automatic logic [15:0] exp_word(input logic [AW-1:0] a);
        logic [SECW-1:0] s;
        s = a[AW-1 -: SECW];
        case (mode_m)
            M_SUS:   return map_m[s] ? P_SUSP : mem_m[a];
            M_AS: begin
                case (a[1:0])
                    2'd0:    return P_MFR;
                    2'd1:    return P_DEV;
                    2'd2:    return {15'd0, prot_sectors[s]};
                    default: return 16'h0000;
                endcase
            end
            M_ERR:   return P_ERR;
            default: return mem_m[a];
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] eo, input logic [2:0] ee);
        tests++;
        if (dq_out !== eo || {dq_oe_lo, dq_oe_mid, dq_oe_top} !== ee) begin
            fails++;
            $display("FAIL %s: dq_out=%h oe=%b expected dq_out=%h oe=%b",
                     req, dq_out, {dq_oe_lo, dq_oe_mid, dq_oe_top}, eo, ee);
        end
    endtask

    // One clock: compute expectation from pre-edge state, update model, check after edge.
    task automatic tick(input string req);
        logic [15:0] w, eo;
        logic [2:0]  ee;
        w = exp_word(addr);
        if (ce_n || oe_n) begin
            eo = 16'h0000; ee = 3'b000;
        end else if (word_mode) begin
            eo = w; ee = 3'b111;
        end else begin
            eo = {8'h00, (dq_top_in ? w[15:8] : w[7:0])}; ee = 3'b100;
        end
        if (prog_we) mem_m[prog_addr] = prog_data;
        if (cmd_reset) begin
            mode_m = M_ARR; map_m = '0;
        end else if (err_flag) begin
            mode_m = M_ERR;
        end else if (mode_m == M_ARR) begin
            if (cmd_autosel) mode_m = M_AS;
            else if (cmd_suspend) begin mode_m = M_SUS; map_m = susp_sectors; end
        end else if (mode_m == M_SUS) begin
            if (cmd_autosel) mode_m = M_AS;
            else if (cmd_resume) begin mode_m = M_ARR; map_m = '0; end
        end
        @(negedge clk);
        check(req, eo, ee);
        prog_we = 0; cmd_reset = 0; cmd_autosel = 0; cmd_suspend = 0;
        cmd_resume = 0; cmd_prog_done = 0; err_flag = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic wm, input logic hi, input string req);
        ce_n = 0; oe_n = 0; addr = a; word_mode = wm; dq_top_in = hi;
        tick(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250117));
        repeat (3) @(negedge clk);
        check("R1", 16'h0000, 3'b000);
        rst_n = 1;
        // load the array through the program port (R12)
        for (int i = 0; i < (1 << AW); i++) begin
            ce_n = 1; prog_we = 1; prog_addr = AW'(i);
            prog_data = 16'(i * 16'h0301) ^ 16'h5A3C;
            tick("R12");
        end
        rd(8'h05, 1, 0, "R1");
        rd(8'h05, 1, 0, "R2");
        rd(8'hC7, 1, 1, "R2");
        rd(8'h33, 0, 0, "R3");
        rd(8'h33, 0, 1, "R3");
        ce_n = 1; oe_n = 0; tick("R4");
        ce_n = 1; oe_n = 1; tick("R4");
        ce_n = 0; oe_n = 1; tick("R5");
        // same-cycle write and read see the old word
        ce_n = 0; oe_n = 0; word_mode = 1; addr = 8'h20;
        prog_we = 1; prog_addr = 8'h20; prog_data = 16'hBEEF; tick("R12");
        rd(8'h20, 1, 0, "R12");
        // erase suspend
        susp_sectors = 4'b0101; cmd_suspend = 1; rd(8'h10, 1, 0, "R6");
        rd(8'h10, 1, 0, "R6");
        rd(8'h50, 1, 0, "R6");
        rd(8'h90, 0, 1, "R6");
        prog_we = 1; prog_addr = 8'h51; prog_data = 16'h1234; cmd_prog_done = 1;
        rd(8'h51, 1, 0, "R7");
        rd(8'h51, 1, 0, "R7");
        rd(8'h11, 1, 0, "R7");
        cmd_resume = 1; rd(8'h10, 1, 0, "R8");
        rd(8'h10, 1, 0, "R8");
        // identifier mode
        prot_sectors = 4'b0100;
        cmd_autosel = 1; rd(8'h00, 1, 0, "R10");
        rd(8'h00, 1, 0, "R10");
        rd(8'h01, 1, 0, "R10");
        rd(8'h82, 1, 0, "R10");
        rd(8'h42, 1, 0, "R10");
        rd(8'h03, 1, 0, "R10");
        rd(8'h01, 0, 1, "R10");
        cmd_suspend = 1; susp_sectors = 4'b1111; rd(8'h00, 1, 0, "R10");
        rd(8'h00, 1, 0, "R10");
        cmd_reset = 1; rd(8'h00, 1, 0, "R11");
        rd(8'h00, 1, 0, "R11");
        // error latch
        err_flag = 1; cmd_autosel = 1; rd(8'h07, 1, 0, "R9");
        rd(8'h07, 1, 0, "R9");
        cmd_autosel = 1; rd(8'h00, 1, 0, "R9");
        cmd_suspend = 1; rd(8'h00, 1, 0, "R9");
        rd(8'h00, 0, 0, "R9");
        cmd_reset = 1; err_flag = 1; rd(8'h07, 1, 0, "R11");
        rd(8'h07, 1, 0, "R11");
        // constrained random
        for (int n = 0; n < 4000; n++) begin
            ce_n = ($urandom % 100) < 15;
            oe_n = ($urandom % 100) < 15;
            word_mode = $urandom % 2;
            dq_top_in = $urandom % 2;
            addr = AW'($urandom);
            prot_sectors = NSEC'($urandom);
            susp_sectors = NSEC'($urandom);
            prog_we = ($urandom % 8) == 0;
            prog_addr = AW'($urandom);
            prog_data = 16'($urandom);
            cmd_reset = ($urandom % 40) == 0;
            err_flag = ($urandom % 70) == 0;
            cmd_autosel = ($urandom % 30) == 0;
            cmd_suspend = ($urandom % 12) == 0;
            cmd_resume = ($urandom % 15) == 0;
            cmd_prog_done = ($urandom % 10) == 0;
            tick("R2/R3/R6/R11 random");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule